// File: doc/BRIEF.md
# Sigma-Delta Bitstream Gain Tap

This block sits on the sample path between a DAC interpolator and the rest of the DAC chain. It folds in a feedback term taken directly from the ADC's one-bit sigma-delta modulator output, the way a sidetone path does. There is no multiplier. The modulator bit chooses whether a programmed 16-bit two's complement coefficient is added to or subtracted from each interpolator sample. The result is clamped to the signed 16-bit range and leaves the block on a registered output.

The coefficient is scaled against full scale. A value of 0x8000 gives a gain of -1.0, 0xC000 gives -0.5, 0xE000 gives -0.25 and 0x0000 disables the tap. On the positive side 0x2000 gives +0.25, 0x4000 gives +0.5 and 0x7FFF gives just under +1.0.

Software loads the coefficient through an 8-bit register write port. The upper byte is staged first. Writing the lower byte moves both bytes into the working coefficient in the same cycle, so no sample ever sees half an update.

The modulator bit arrives with its own strobe and is held between strobes. When the strobe fires in the same cycle as a sample, the new bit applies to that sample.

Top module: `sd_gain_tap`

## Requirements
- R1: Synchronous active-high reset clears `smp_out` to 0, `smp_out_valid` to 0 and the working coefficient to 0.
- R2: `smp_out_valid` is high exactly in the cycle after a cycle in which `smp_in_valid` was high, and low otherwise.
- R3: With an effective modulator bit of 1, the output is `smp_in + coef`, with both values read as signed 16-bit.
- R4: With an effective modulator bit of 0, the output is `smp_in - coef`.
- R5: A result above 32767 is clamped to 0x7FFF and a result below -32768 is clamped to 0x8000. The output never wraps.
- R6: While the working coefficient is 0, the output equals the input sample bit for bit, whatever the modulator bit.
- R7: A write to address 6 (upper byte) only stages the byte and leaves the working coefficient unchanged. A write to address 7 (lower byte) loads {staged upper byte, written byte} into the working coefficient, and the new value applies from the next cycle on.
- R8: Writes to any address other than 6 and 7 leave the coefficient and the staged byte unchanged.
- R9: The effective modulator bit is `mod_bit` when `mod_valid` is high. Otherwise it is the bit captured at the most recent `mod_valid` strobe, which is 0 after reset.
- R10: In a cycle after one with no input sample, `smp_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_bit | input | 1 | Modulator bitstream bit (1 adds, 0 subtracts) |
| mod_valid | input | 1 | Strobe that marks `mod_bit` as new |
| smp_in | input | 16 | Interpolator sample, signed |
| smp_in_valid | input | 1 | Input sample strobe |
| smp_out | output | 16 | Sample with the tap applied, signed, registered |
| smp_out_valid | output | 1 | Output sample strobe |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address (6 = upper byte, 7 = lower byte) |
| reg_wdata | input | 8 | Register write data |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing and the absence of spurious strobes;
- that the output holds while no sample arrives;
- that a zero coefficient passes samples through unchanged;
- that an added non-negative coefficient never lowers the sample;
- that staging or stray writes never disturb the working coefficient.

Only the bench scenarios can show the following:
- the exact sums and differences;
- clamping at both rails, including a coefficient of -1.0;
- the hold and override behaviour of the modulator bit;
- that a lower-byte write joins the byte staged earlier.

// File: rtl/sdgt_pkg.sv
package sdgt_pkg;

  // Direction chosen by the modulator bitstream.
  typedef enum logic {
    TAP_SUB = 1'b0,
    TAP_ADD = 1'b1
  } tap_dir_e;

endpackage

// File: rtl/sdgt_coef_bank.sv
// Coefficient storage: upper bytes are staged, the lowest byte commits all.
module sdgt_coef_bank #(
  parameter int REG_W     = 8,
  parameter int NBYTES    = 2,
  parameter int ADDR_W    = 3,
  parameter int ADDR_BASE = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [REG_W-1:0]        wr_data,
  output logic [REG_W*NBYTES-1:0] coef
);
  localparam int COEF_W  = REG_W * NBYTES;
  localparam int STAGE_W = REG_W * (NBYTES - 1);
  localparam logic [ADDR_W-1:0] COMMIT_ADDR = ADDR_W'(ADDR_BASE + NBYTES - 1);

  logic [STAGE_W-1:0] stage_q;
  logic [COEF_W-1:0]  coef_q;
  logic [NBYTES-2:0]  stage_hit;

  // One decoder per staged byte; address ADDR_BASE holds the top byte.
  for (genvar i = 0; i < NBYTES - 1; i++) begin : g_hit
    localparam logic [ADDR_W-1:0] BYTE_ADDR = ADDR_W'(ADDR_BASE + i);
    assign stage_hit[i] = wr_en && (wr_addr == BYTE_ADDR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      coef_q  <= '0;
    end else begin
      for (int i = 0; i < NBYTES - 1; i++) begin
        if (stage_hit[i]) begin
          stage_q[(NBYTES-1-i)*REG_W-1 -: REG_W] <= wr_data;
        end
      end
      if (wr_en && (wr_addr == COMMIT_ADDR)) begin
        coef_q <= {stage_q, wr_data};
      end
    end
  end

  assign coef = coef_q;

endmodule

// File: rtl/sdgt_bit_hold.sv
// Keeps the latest modulator bit between strobes; a fresh strobe wins.
module sdgt_bit_hold (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              bit_valid,
  output sdgt_pkg::tap_dir_e dir,
  output logic              held_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
    end else if (bit_valid) begin
      held_q <= bit_in;
    end
  end

  always_comb begin
    dir = sdgt_pkg::tap_dir_e'(bit_valid ? bit_in : held_q);
  end

endmodule

// File: rtl/sdgt_sat_accum.sv
// Signed add or subtract with clamp to the DATA_W two's complement range.
module sdgt_sat_accum #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]  sample,
  input  logic [DATA_W-1:0]  coef,
  input  sdgt_pkg::tap_dir_e dir,
  output logic [DATA_W-1:0]  result
);
  localparam int EXT_W = DATA_W + 2;

  logic signed [EXT_W-1:0] s_ext;
  logic signed [EXT_W-1:0] c_ext;
  logic signed [EXT_W-1:0] sum;
  logic                    in_range;

  always_comb begin
    s_ext = {{2{sample[DATA_W-1]}}, sample};
    c_ext = {{2{coef[DATA_W-1]}}, coef};
    if (dir == sdgt_pkg::TAP_ADD) begin
      sum = s_ext + c_ext;
    end else begin
      sum = s_ext - c_ext;
    end
    // The result fits when every bit above the sign position matches the sign.
    in_range = (sum[EXT_W-1:DATA_W-1] == '0) || (sum[EXT_W-1:DATA_W-1] == '1);
    if (in_range) begin
      result = sum[DATA_W-1:0];
    end else if (sum[EXT_W-1]) begin
      result = {1'b1, {(DATA_W-1){1'b0}}};
    end else begin
      result = {1'b0, {(DATA_W-1){1'b1}}};
    end
  end

endmodule

// File: rtl/sd_gain_tap.sv
module sd_gain_tap #(
  parameter int DATA_W    = 16,
  parameter int REG_W     = 8,
  parameter int ADDR_W    = 3,
  parameter int ADDR_BASE = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mod_bit,
  input  logic              mod_valid,
  input  logic [DATA_W-1:0] smp_in,
  input  logic              smp_in_valid,
  output logic [DATA_W-1:0] smp_out,
  output logic              smp_out_valid,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata
);
  localparam int NBYTES = DATA_W / REG_W;

  logic [DATA_W-1:0]  coef_q;
  logic               held_q;
  sdgt_pkg::tap_dir_e dir;
  logic [DATA_W-1:0]  tap_sum;
  logic [DATA_W-1:0]  out_q;
  logic               out_vld_q;

  sdgt_coef_bank #(
    .REG_W    (REG_W),
    .NBYTES   (NBYTES),
    .ADDR_W   (ADDR_W),
    .ADDR_BASE(ADDR_BASE)
  ) u_coef (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_wr),
    .wr_addr(reg_addr),
    .wr_data(reg_wdata),
    .coef   (coef_q)
  );

  sdgt_bit_hold u_bit (
    .clk      (clk),
    .rst      (rst),
    .bit_in   (mod_bit),
    .bit_valid(mod_valid),
    .dir      (dir),
    .held_q   (held_q)
  );

  sdgt_sat_accum #(
    .DATA_W(DATA_W)
  ) u_acc (
    .sample(smp_in),
    .coef  (coef_q),
    .dir   (dir),
    .result(tap_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q     <= '0;
      out_vld_q <= 1'b0;
    end else begin
      out_vld_q <= smp_in_valid;
      if (smp_in_valid) begin
        out_q <= tap_sum;
      end
    end
  end

  assign smp_out       = out_q;
  assign smp_out_valid = out_vld_q;

endmodule

// File: rtl/sd_gain_tap_chk.sv
module sd_gain_tap_chk #(
  parameter int DATA_W    = 16,
  parameter int REG_W     = 8,
  parameter int ADDR_W    = 3,
  parameter int ADDR_BASE = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              mod_bit,
  input logic              mod_valid,
  input logic [DATA_W-1:0] smp_in,
  input logic              smp_in_valid,
  input logic [DATA_W-1:0] smp_out,
  input logic              smp_out_valid,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] coef_q,
  input logic              held_q
);
  localparam int NBYTES = DATA_W / REG_W;
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(ADDR_BASE + NBYTES - 1);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(ADDR_BASE);

  logic eff_add;
  logic in_map;
  assign eff_add = mod_valid ? mod_bit : held_q;
  assign in_map  = ({1'b0, reg_addr} >= (ADDR_W+1)'(ADDR_BASE)) &&
                   ({1'b0, reg_addr} <= (ADDR_W+1)'(ADDR_BASE + NBYTES - 1));

  // R2
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    smp_in_valid |=> smp_out_valid);
  // R2
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !smp_in_valid |=> !smp_out_valid);
  // R10
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !smp_in_valid |=> $stable(smp_out));
  // R6
  a_r6_zero_pass: assert property (@(posedge clk) disable iff (rst)
    (smp_in_valid && coef_q == '0) |=> smp_out == $past(smp_in));
  // R5, R3
  a_r5_add_no_drop: assert property (@(posedge clk) disable iff (rst)
    (smp_in_valid && eff_add && !coef_q[DATA_W-1])
      |=> $signed(smp_out) >= $signed($past(smp_in)));
  // R7
  a_r7_hi_staged: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == HI_A && HI_A != LO_A) |=> $stable(coef_q));
  // R8
  a_r8_other_addr: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !in_map) |=> $stable(coef_q));
  // R7
  a_r7_no_write_no_change: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> $stable(coef_q));

endmodule

bind sd_gain_tap sd_gain_tap_chk #(
  .DATA_W   (DATA_W),
  .REG_W    (REG_W),
  .ADDR_W   (ADDR_W),
  .ADDR_BASE(ADDR_BASE)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mod_bit      (mod_bit),
  .mod_valid    (mod_valid),
  .smp_in       (smp_in),
  .smp_in_valid (smp_in_valid),
  .smp_out      (smp_out),
  .smp_out_valid(smp_out_valid),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .coef_q       (coef_q),
  .held_q       (held_q)
);

// File: tb/sd_gain_tap_test.sv
module sd_gain_tap_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mod_bit = 1'b0;
  logic        mod_valid = 1'b0;
  logic [15:0] smp_in = '0;
  logic        smp_in_valid = 1'b0;
  logic [15:0] smp_out;
  logic        smp_out_valid;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  m_stage = '0;
  logic [15:0] m_coef  = '0;
  logic        m_held  = 1'b0;
  logic [15:0] last_out = '0;
  bit          done = 0;

  always #5 clk = ~clk;

  sd_gain_tap uut (
    .clk(clk), .rst(rst), .mod_bit(mod_bit), .mod_valid(mod_valid),
    .smp_in(smp_in), .smp_in_valid(smp_in_valid), .smp_out(smp_out),
    .smp_out_valid(smp_out_valid), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata)
  );

  function automatic logic [15:0] model(logic [15:0] s, logic [15:0] c, logic add);
    int r;
    r = add ? int'($signed(s)) + int'($signed(c)) : int'($signed(s)) - int'($signed(c));
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r[15:0];
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic write_reg(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    smp_in_valid = 1'b0; mod_valid = 1'b0;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (a == 3'd6) m_stage = d;
    if (a == 3'd7) m_coef = {m_stage, d};
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic send(logic [15:0] s, logic b, logic strobe, string req);
    logic eff;
    @(negedge clk);
    smp_in = s; smp_in_valid = 1'b1; mod_bit = b; mod_valid = strobe;
    @(posedge clk);
    eff = strobe ? b : m_held;
    if (strobe) m_held = b;
    exp_q.push_back(model(s, m_coef, eff));
    tag_q.push_back(req);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    smp_in_valid = 1'b0; mod_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: valid must appear exactly when an expected item is due (R2).
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (smp_out_valid !== (exp_q.size() > 0)) begin
        fails++;
        $display("FAIL R2: valid actual %b expected %b", smp_out_valid, exp_q.size() > 0);
      end
      if (exp_q.size() > 0) begin
        string t;
        logic [15:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, smp_out, e);
      end else begin
        check("R10", smp_out, last_out);
      end
      last_out = smp_out;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", smp_out, 16'h0000);
    check("R1", {15'd0, smp_out_valid}, 16'h0000);
    rst = 1'b0;
    // R1/R6: coefficient starts at zero, samples pass unchanged
    send(16'h1234, 1'b1, 1'b1, "R6");
    send(16'h8001, 1'b0, 1'b1, "R6");
    idle(2);
    // R7: upper byte alone has no effect
    write_reg(3'd6, 8'h40);
    send(16'h0100, 1'b1, 1'b1, "R7");
    idle(1);
    write_reg(3'd7, 8'h00);  // coef 0x4000 = +0.5
    send(16'd1000, 1'b1, 1'b1, "R3");
    send(16'd1000, 1'b0, 1'b1, "R4");
    // R5: clamp both rails
    send(16'h7000, 1'b1, 1'b1, "R5");
    send(16'h8AD0, 1'b0, 1'b1, "R5");
    idle(3);
    // R8: stray addresses ignored, staged byte kept
    write_reg(3'd0, 8'hFF);
    write_reg(3'd5, 8'h11);
    send(16'd200, 1'b1, 1'b1, "R8");
    idle(1);
    // coefficient of -1.0
    write_reg(3'd6, 8'h80);
    write_reg(3'd7, 8'h00);
    send(16'h0000, 1'b0, 1'b1, "R5");
    send(16'hFFFF, 1'b1, 1'b1, "R5");
    // R9: held bit and same-cycle override
    write_reg(3'd6, 8'hE0);
    write_reg(3'd7, 8'h00);  // -0.25
    send(16'd500, 1'b1, 1'b1, "R9");
    send(16'd500, 1'b0, 1'b0, "R9");
    send(16'd500, 1'b0, 1'b0, "R9");
    send(16'd500, 1'b0, 1'b1, "R9");
    send(16'd500, 1'b1, 1'b0, "R9");
    idle(2);
    // Mixed patterns with several coefficients
    for (int k = 0; k < 6; k++) begin
      logic [7:0] hb;
      hb = (k == 0) ? 8'hC0 : (k == 1) ? 8'h20 : (k == 2) ? 8'h7F : 8'($urandom);
      write_reg(3'd6, hb);
      write_reg(3'd7, (k == 2) ? 8'hFF : 8'($urandom));
      for (int j = 0; j < 40; j++) begin
        send(16'($urandom), 1'($urandom), 1'($urandom), (j % 2 == 0) ? "R3" : "R4");
        if (j % 7 == 0) idle(1);
      end
      idle(1);
    end
    // R6 again after returning to zero
    write_reg(3'd6, 8'h00);
    write_reg(3'd7, 8'h00);
    for (int j = 0; j < 20; j++) send(16'($urandom), 1'($urandom), 1'b1, "R6");
    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule